// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing control and status layer of a UART. A host reaches it through a simple 32-bit register bus addressed by byte offset, one register per word. The block does not store bytes itself. A data write hands a byte to an external 128-entry transmit queue. A data read takes the head byte from an external 128-entry receive queue, and each queue entry carries its own break, framing and parity flags.

The block holds the line-format, modem-line and divisor settings and drives them to the serializer and deserializer. It keeps a sticky overrun flag, builds two interrupt causes from the queue levels, and drives one level interrupt. A loopback setting turns the serializer's output back into the deserializer's input and holds the external transmit line at idle.

Top module: `uart_regfront`

## Requirements
- R1: After reset the line-format register (word 3) reads 0x03 (8-bit words, one stop bit, no parity, no break), the modem control (word 4), divisors (words 5 and 6) and interrupt enables read 0, and `irq` is 0.
- R2: A write to word 0 pushes `bus_wdata[7:0]` to the transmit queue (`tx_push` high that cycle) only while `tx_count` is below 128; when the queue is full the write is dropped.
- R3: A read of word 0 returns the head byte in bits 7:0 and pops the receive queue when it is not empty; when it is empty it returns 0 and does not pop.
- R4: Line status (word 1) reads bit0 = transmit queue not full, bit1 = receive queue not empty, bit3 = overrun, bit6 = transmit queue empty and `ser_idle` high, with all other bits 0 apart from the flag bits of R5.
- R5: Line status bit5 (break), bit4 (framing) and bit2 (parity) show the flags of the head receive entry, and read 0 while the receive queue is empty.
- R6: An `rx_overrun` pulse sets a sticky overrun bit. A line status read reports it and clears it. A pulse in the same cycle as the read is reported by that read and is not kept.
- R7: The interrupt register (word 7) holds the receive enable in bit5 and the transmit enable in bit4. Bit1 reads as receive pending (queue not empty) and bit0 as transmit pending (queue not full). Writes to bits 1 and 0 have no effect.
- R8: `irq` is registered: one cycle after the queue levels, it equals (receive enable AND receive queue not empty) OR (transmit enable AND transmit queue not full).
- R9: The line-format register drives `word_len` from bits 1:0, `two_stop` from bit2, `par_en` from bit3, `par_even` from bit4 and `force_brk` from bit5. The modem control register drives `dtr`, `rts`, `dcd` and `ri` from bits 0 to 3. `div_lo` (16 bits, word 5) and `div_hi` (8 bits, word 6) read back as written, with the upper bits masked.
- R10: Reading word 8 returns `tx_count` and reading word 9 returns `rx_count`. Any write to word 9 raises `rx_flush` in that cycle. A write to word 8 has no effect.
- R11: With modem control bit4 (loopback) set, `des_in` follows `ser_txd` and `ext_txd` is held at 1. With bit4 clear, `ext_txd` follows `ser_txd` and `des_in` follows `ext_rxd`.
- R12: Read data appears on `bus_rdata` one cycle after the read cycle. Word 2 returns `modem_in`, and writes to word 2 are ignored. Words 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_push | output | 1 | Push strobe to the transmit queue |
| tx_data | output | 8 | Byte to push |
| tx_count | input | 8 | Transmit queue occupancy |
| ser_idle | input | 1 | Serializer has no frame in flight |
| rx_pop | output | 1 | Pop strobe to the receive queue |
| rx_flush | output | 1 | Empty the receive queue |
| rx_head_data | input | 8 | Head byte of the receive queue |
| rx_head_brk | input | 1 | Head entry was a break |
| rx_head_frm | input | 1 | Head entry had a framing error |
| rx_head_par | input | 1 | Head entry had a parity error |
| rx_count | input | 8 | Receive queue occupancy |
| rx_overrun | input | 1 | Byte lost on a full receive queue |
| word_len | output | 2 | 0..3 = 5..8 data bits |
| two_stop | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | 1 = even parity |
| force_brk | output | 1 | Hold the line in break |
| div_lo | output | 16 | Divisor low word |
| div_hi | output | 8 | Divisor high byte |
| dtr | output | 1 | Modem line DTR |
| rts | output | 1 | Modem line RTS |
| dcd | output | 1 | Modem line DCD |
| ri | output | 1 | Modem line RI |
| modem_in | input | 4 | Modem input lines |
| ser_txd | input | 1 | Serializer output |
| ext_txd | output | 1 | External transmit pin |
| ext_rxd | input | 1 | External receive pin |
| des_in | output | 1 | Deserializer input |
| irq | output | 1 | Level interrupt |

## Verification
Two things can fall in the same cycle: an overrun event arriving from the deserializer, and a host read of line status, which clears the sticky bit. The bench raises `rx_overrun` during the very cycle of a line status read. It judges that the read returns bit3 set and that the next read returns it clear. The pop strobe and a new receive entry also meet in one cycle in the random phase, and every data and status read is compared with the bench's queue model.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int IDX_DATA  = 0;
  localparam int IDX_LSR   = 1;
  localparam int IDX_MSR   = 2;
  localparam int IDX_LCR   = 3;
  localparam int IDX_MCR   = 4;
  localparam int IDX_DIVL  = 5;
  localparam int IDX_DIVH  = 6;
  localparam int IDX_ISC   = 7;
  localparam int IDX_TXRES = 8;
  localparam int IDX_RXRES = 9;
  localparam logic [5:0] LCR_RESET = 6'h03;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DIVL_W = 16,
  parameter int DIVH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [31:0]       wdata,
  output logic [5:0]        lcr,
  output logic [4:0]        mcr,
  output logic [DIVL_W-1:0] divl,
  output logic [DIVH_W-1:0] divh,
  output logic              rx_ie,
  output logic              tx_ie
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr   <= LCR_RESET;
      mcr   <= '0;
      divl  <= '0;
      divh  <= '0;
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (wr_en) begin
      case (idx)
        IDX_W'(IDX_LCR):  lcr  <= wdata[5:0];
        IDX_W'(IDX_MCR):  mcr  <= wdata[4:0];
        IDX_W'(IDX_DIVL): divl <= wdata[DIVL_W-1:0];
        IDX_W'(IDX_DIVH): divh <= wdata[DIVH_W-1:0];
        IDX_W'(IDX_ISC): begin
          rx_ie <= wdata[5];
          tx_ie <= wdata[4];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_stat.sv
module uart_reg_stat (
  input  logic clk,
  input  logic rst,
  input  logic lsr_rd,
  input  logic ovr_evt,
  input  logic rx_ie,
  input  logic tx_ie,
  input  logic rx_nempty,
  input  logic tx_nfull,
  output logic ovr_view,
  output logic irq
);
  logic ovr_q;

  // an event in the read cycle is shown by that read, so nothing is lost
  assign ovr_view = ovr_q | ovr_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ovr_q <= lsr_rd ? 1'b0 : ovr_view;
      irq   <= (rx_ie & rx_nempty) | (tx_ie & tx_nfull);
    end
  end
endmodule

// File: rtl/uart_reg_rdmux.sv
module uart_reg_rdmux
  import uart_reg_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DIVL_W = 16,
  parameter int DIVH_W = 8,
  parameter int MSR_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        head_byte,
  input  logic [6:0]        lsr,
  input  logic [MSR_W-1:0]  msr,
  input  logic [5:0]        lcr,
  input  logic [4:0]        mcr,
  input  logic [DIVL_W-1:0] divl,
  input  logic [DIVH_W-1:0] divh,
  input  logic [5:0]        isc,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  output logic [31:0]       rdata
);
  logic [31:0] word;

  always_comb begin
    case (idx)
      IDX_W'(IDX_DATA):  word = 32'(head_byte);
      IDX_W'(IDX_LSR):   word = 32'(lsr);
      IDX_W'(IDX_MSR):   word = 32'(msr);
      IDX_W'(IDX_LCR):   word = 32'(lcr);
      IDX_W'(IDX_MCR):   word = 32'(mcr);
      IDX_W'(IDX_DIVL):  word = 32'(divl);
      IDX_W'(IDX_DIVH):  word = 32'(divh);
      IDX_W'(IDX_ISC):   word = 32'(isc);
      IDX_W'(IDX_TXRES): word = 32'(tx_cnt);
      IDX_W'(IDX_RXRES): word = 32'(rx_cnt);
      default:           word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_reg_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 6,
  parameter int DIVL_W = 16,
  parameter int DIVH_W = 8,
  parameter int MSR_W  = 4,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ser_idle,
  output logic              rx_pop,
  output logic              rx_flush,
  input  logic [7:0]        rx_head_data,
  input  logic              rx_head_brk,
  input  logic              rx_head_frm,
  input  logic              rx_head_par,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_overrun,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic              par_en,
  output logic              par_even,
  output logic              force_brk,
  output logic [DIVL_W-1:0] div_lo,
  output logic [DIVH_W-1:0] div_hi,
  output logic              dtr,
  output logic              rts,
  output logic              dcd,
  output logic              ri,
  input  logic [MSR_W-1:0]  modem_in,
  input  logic              ser_txd,
  output logic              ext_txd,
  input  logic              ext_rxd,
  output logic              des_in,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NFLAG = 3;

  logic [IDX_W-1:0] idx;
  logic acc_rd, acc_wr, rx_nempty, tx_nfull, tx_empty, lsr_rd;
  logic [5:0] lcr;
  logic [4:0] mcr;
  logic rx_ie, tx_ie, ovr_view;
  logic [NFLAG-1:0] raw_flag, shown_flag;
  logic [6:0] lsr;
  logic [7:0] head_byte;
  logic unused_addr;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];
  assign acc_rd      = bus_sel & ~bus_wr;
  assign acc_wr      = bus_sel & bus_wr;
  assign rx_nempty   = (rx_count != '0);
  assign tx_nfull    = (tx_count < CNT_W'(DEPTH));
  assign tx_empty    = (tx_count == '0) & ser_idle;
  assign lsr_rd      = acc_rd & (idx == IDX_W'(IDX_LSR));

  // queue strobes
  assign tx_push  = acc_wr & (idx == IDX_W'(IDX_DATA)) & tx_nfull;
  assign tx_data  = bus_wdata[7:0];
  assign rx_pop   = acc_rd & (idx == IDX_W'(IDX_DATA)) & rx_nempty;
  assign rx_flush = acc_wr & (idx == IDX_W'(IDX_RXRES));

  // head flags are meaningful only while an entry is present
  assign raw_flag = {rx_head_brk, rx_head_frm, rx_head_par};
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign shown_flag[g] = raw_flag[g] & rx_nempty;
  end
  assign head_byte = rx_nempty ? rx_head_data : 8'h00;

  assign lsr = {tx_empty, shown_flag[2], shown_flag[1], ovr_view,
                shown_flag[0], rx_nempty, tx_nfull};

  uart_reg_ctrl #(.IDX_W(IDX_W), .DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .idx(idx), .wdata(bus_wdata),
    .lcr(lcr), .mcr(mcr), .divl(div_lo), .divh(div_hi),
    .rx_ie(rx_ie), .tx_ie(tx_ie)
  );

  uart_reg_stat u_stat (
    .clk(clk), .rst(rst), .lsr_rd(lsr_rd), .ovr_evt(rx_overrun),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .rx_nempty(rx_nempty), .tx_nfull(tx_nfull),
    .ovr_view(ovr_view), .irq(irq)
  );

  uart_reg_rdmux #(.IDX_W(IDX_W), .DIVL_W(DIVL_W), .DIVH_W(DIVH_W),
                   .MSR_W(MSR_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(acc_rd), .idx(idx), .head_byte(head_byte),
    .lsr(lsr), .msr(modem_in), .lcr(lcr), .mcr(mcr), .divl(div_lo),
    .divh(div_hi), .isc({rx_ie, tx_ie, 2'b00, rx_nempty, tx_nfull}),
    .tx_cnt(tx_count), .rx_cnt(rx_count), .rdata(bus_rdata)
  );

  assign word_len  = lcr[1:0];
  assign two_stop  = lcr[2];
  assign par_en    = lcr[3];
  assign par_even  = lcr[4];
  assign force_brk = lcr[5];
  assign dtr       = mcr[0];
  assign rts       = mcr[1];
  assign dcd       = mcr[2];
  assign ri        = mcr[3];

  // loopback turns the serializer back into the deserializer
  assign ext_txd = mcr[4] ? 1'b1 : ser_txd;
  assign des_in  = mcr[4] ? ser_txd : ext_rxd;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_push,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_pop,
  input logic             rx_flush,
  input logic [CNT_W-1:0] rx_count,
  input logic             irq,
  input logic             ext_txd,
  input logic             ext_rxd,
  input logic             des_in
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (tx_count < CNT_W'(DEPTH)));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (rx_count != '0));

  a_r10_flush_not_pop: assert property (@(posedge clk) disable iff (rst)
    !(rx_flush && rx_pop));

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_count != '0 || tx_count < CNT_W'(DEPTH)));

  a_r11_low_pin_means_direct: assert property (@(posedge clk) disable iff (rst)
    !ext_txd |-> (des_in == ext_rxd));
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_push(tx_push), .tx_count(tx_count),
  .rx_pop(rx_pop), .rx_flush(rx_flush), .rx_count(rx_count), .irq(irq),
  .ext_txd(ext_txd), .ext_rxd(ext_rxd), .des_in(des_in)
);

// File: tb/test_uart_regfront.sv
`timescale 1ns/1ps
module test_uart_regfront;
  localparam int DEPTH = 128;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tx_push, rx_pop, rx_flush;
  logic [7:0] tx_data;
  logic [CNT_W-1:0] tx_count = 0, rx_count = 0;
  logic ser_idle = 1;
  logic [7:0] rx_head_data = 0;
  logic rx_head_brk = 0, rx_head_frm = 0, rx_head_par = 0;
  logic rx_overrun = 0;
  logic [1:0] word_len;
  logic two_stop, par_en, par_even, force_brk, dtr, rts, dcd, ri;
  logic [15:0] div_lo;
  logic [7:0] div_hi;
  logic [3:0] modem_in = 4'hA;
  logic ser_txd = 1, ext_rxd = 1, ext_txd, des_in, irq;

  int checks = 0, errors = 0;
  logic [10:0] rxq[$];   // {brk, frm, par, data}
  logic [7:0]  txq[$];
  logic ov_m = 0;
  logic inj_v = 0, drain = 0, fill = 0;
  logic [10:0] inj_e = 0;

  always #2.5 clk = ~clk;

  uart_regfront i_uart_regfront (.*);

  // queue model driven by the design's strobes
  always @(posedge clk) begin
    if (rst) begin
      rxq.delete(); txq.delete(); ov_m = 0;
    end else begin
      if (bus_sel && !bus_wr && bus_addr[5:2] == 4'd1) ov_m = 0;
      else if (rx_overrun) ov_m = 1;
      if (tx_push) txq.push_back(tx_data);
      if (drain && txq.size() > 0) void'(txq.pop_front());
      if (fill) while (txq.size() < DEPTH) txq.push_back(8'h55);
      if (rx_pop) void'(rxq.pop_front());
      if (rx_flush) rxq.delete();
      if (inj_v) rxq.push_back(inj_e);
    end
    tx_count     <= CNT_W'(txq.size());
    rx_count     <= CNT_W'(rxq.size());
    rx_head_data <= rxq.size() > 0 ? rxq[0][7:0] : 8'h00;
    rx_head_par  <= rxq.size() > 0 ? rxq[0][8]  : 1'b0;
    rx_head_frm  <= rxq.size() > 0 ? rxq[0][9]  : 1'b0;
    rx_head_brk  <= rxq.size() > 0 ? rxq[0][10] : 1'b0;
  end

  function automatic logic [31:0] exp_lsr();
    logic [31:0] v = 0;
    logic ne = rxq.size() != 0;
    logic [10:0] h = ne ? rxq[0] : 11'h0;
    v[0] = txq.size() < DEPTH;
    v[1] = ne;
    v[2] = ne & h[8];
    v[3] = ov_m | rx_overrun;
    v[4] = ne & h[9];
    v[5] = ne & h[10];
    v[6] = (txq.size() == 0) && ser_idle;
    return v;
  endfunction

  function automatic logic [31:0] exp_data();
    return rxq.size() != 0 ? 32'(rxq[0][7:0]) : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int word, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'(word * 4);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input int word, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'(word * 4); bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic inject(input logic [10:0] e);
    @(negedge clk); inj_v = 1; inj_e = e;
    @(negedge clk); inj_v = 0;
  endtask

  task automatic pulse_drain();
    @(negedge clk); drain = 1;
    @(negedge clk); drain = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    void'($urandom(32'd20211));
    repeat (4) @(negedge clk);
    rst = 0;
    idle(1);

    // R1 reset state
    rd(3, d); chk("R1 lcr reset", d, 32'h03);
    rd(4, d); chk("R1 mcr reset", d, 32'h0);
    rd(5, d); chk("R1 divl reset", d, 32'h0);
    rd(7, d); chk("R7 R1 isc reset", d, 32'h01);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R9 control fields and R12 read-only/unmapped words
    wr(3, 32'hFFFF_FF3A); rd(3, d); chk("R9 lcr readback", d, 32'h3A);
    chk("R9 lcr fields", {word_len, two_stop, par_en, par_even, force_brk},
        {2'b10, 1'b0, 1'b1, 1'b1, 1'b1});
    wr(4, 32'h0F); rd(4, d); chk("R9 mcr readback", d, 32'h0F);
    chk("R9 modem lines", {dtr, rts, dcd, ri}, 4'hF);
    wr(5, 32'hFFFF_ABCD); rd(5, d); chk("R9 divl", d, 32'hABCD);
    wr(6, 32'hFFFF_FF12); rd(6, d); chk("R9 divh", d, 32'h12);
    chk("R9 divisor pins", {div_hi, div_lo}, 24'h12ABCD);
    wr(2, 32'h5); rd(2, d); chk("R12 msr ignores write", d, 32'hA);
    for (int w = 10; w < 16; w++) begin
      rd(w, d); chk("R12 unmapped", d, 32'h0);
    end

    // R2 pushes, R10 residue
    wr(0, 32'h1C1); wr(0, 32'h42); wr(0, 32'h99);
    rd(8, d); chk("R10 tx residue", d, 32'd3);
    chk("R2 pushed byte", 32'(txq[0]), 32'hC1);
    ser_idle = 1; rd(1, d); chk("R4 lsr tx busy", d, exp_lsr());
    wr(8, 32'h0); rd(8, d); chk("R10 tx residue write ignored", d, 32'd3);
    @(negedge clk); fill = 1; @(negedge clk); fill = 0;
    rd(1, d); chk("R4 lsr tx full", d, exp_lsr());
    wr(0, 32'h77); rd(8, d); chk("R2 full drops write", d, 32'd128);
    while (txq.size() > 0) pulse_drain();
    ser_idle = 0; rd(1, d); chk("R4 txe needs idle", d, 32'h03 & ~32'h2);
    ser_idle = 1; rd(1, d); chk("R4 txe", d, 32'h41);

    // R3 and R5 receive path
    rd(0, d); chk("R3 empty read", d, 32'h0);
    rd(9, d); chk("R3 empty read no pop", d, 32'd0);
    inject({3'b110, 8'h5A}); inject({3'b001, 8'h3C});
    rd(1, d); chk("R5 head flags", d, exp_lsr());
    chk("R5 head flags value", d, 32'h73);
    rd(0, d); chk("R3 head byte", d, 32'h5A);
    rd(1, d); chk("R5 next head flags", d, 32'h47);
    rd(0, d); chk("R3 second byte", d, 32'h3C);
    rd(1, d); chk("R5 empty hides flags", d, 32'h41);

    // R6 overrun sticky and same-cycle read
    @(negedge clk); rx_overrun = 1; @(negedge clk); rx_overrun = 0;
    rd(1, d); chk("R6 overrun set", d, 32'h49);
    rd(1, d); chk("R6 overrun cleared", d, 32'h41);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'h04; rx_overrun = 1;
    @(negedge clk);
    bus_sel = 0; rx_overrun = 0;
    chk("R6 same-cycle event reported", bus_rdata, 32'h49);
    rd(1, d); chk("R6 same-cycle event not kept", d, 32'h41);

    // R7 and R8 interrupt
    wr(7, 32'h23); idle(2);
    rd(7, d); chk("R7 pending bits read-only", d, 32'h21);
    chk("R8 rx enable, empty", 32'(irq), 32'h0);
    inject({3'b000, 8'h11}); idle(2);
    chk("R8 rx irq", 32'(irq), 32'h1);
    wr(7, 32'h10); idle(2);
    chk("R8 tx irq", 32'(irq), 32'h1);
    wr(7, 32'h00); idle(2);
    chk("R8 disabled", 32'(irq), 32'h0);

    // R10 flush
    inject({3'b000, 8'h22});
    wr(9, 32'h0); rd(9, d); chk("R10 flush", d, 32'd0);

    // R11 loopback
    wr(4, 32'h10);
    ser_txd = 0; ext_rxd = 1; #1;
    chk("R11 lb pin idle", 32'(ext_txd), 32'h1);
    chk("R11 lb des", 32'(des_in), 32'h0);
    ser_txd = 1; ext_rxd = 0; #1;
    chk("R11 lb des follows ser", 32'(des_in), 32'h1);
    wr(4, 32'h00);
    ser_txd = 0; ext_rxd = 1; #1;
    chk("R11 direct tx", 32'(ext_txd), 32'h0);
    chk("R11 direct rx", 32'(des_in), 32'h1);
    ser_txd = 1;

    // random phase
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 7)
        0: if (rxq.size() < 120) inject(11'($urandom));
        1: begin e = exp_data(); rd(0, d); chk("R3 random data", d, e); end
        2: begin e = exp_lsr();  rd(1, d); chk("R4 random lsr", d, e); end
        3: wr(0, $urandom);
        4: pulse_drain();
        5: begin @(negedge clk); rx_overrun = 1; @(negedge clk); rx_overrun = 0; end
        default: begin
          e = 32'(rxq.size()); rd(9, d); chk("R10 random rx residue", d, e);
          e = 32'(txq.size()); rd(8, d); chk("R10 random tx residue", d, e);
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule